// File: doc/BRIEF.md
# Dual-Mode Low-Rate Averaging Engine

This block turns a stream of per-sample instantaneous values into low-rate averages. On every valid sample it accumulates active power, reactive power, the square of the current sample and the square of the voltage sample. When an averaging interval closes, it divides each sum by the number of samples that entered it, adds a programmable offset to the two power results, and presents all four results together with a one-cycle completion pulse. Samples normally arrive at a nominal 4000 per second, so an interval of N samples lasts N/4000 seconds.

Two interval rules are available. In fixed mode the interval is a programmable sample count, raised to a floor of 100 when programmed lower. In line-synchronized mode the interval is bounded by sign changes of the voltage sample. It spans a programmable number of half-cycles, so its length follows the line frequency and N is whatever count of samples that span happened to contain. For example, 100 half-cycles at 51 Hz gives roughly 3921 samples. If the voltage stops crossing zero, a fallback lets intervals keep closing.

Top module: `avg_lowrate_engine`

## Requirements
- R1: With the mode input at 0 (fixed mode), an interval closes on the sample that brings its count to the programmed sample count. Each result is the sum over that interval divided by that count, truncated toward zero.
- R2: A programmed sample count below 100 behaves exactly as 100 in every rule that uses it.
- R3: The power outputs are the signed mean of the P and Q samples, each plus its own signed offset added after the division. The current and voltage outputs are the unsigned mean of the squared samples and carry no offset.
- R4: With the mode input at 1 (synchronized mode), a zero crossing is a sample whose voltage sign bit (the MSB) differs from that of the previous valid sample. After reset, samples are discarded up to and including the first crossing. An interval closes on the sample that completes the programmed half-cycle count of crossings, and a count of 0 acts as 1.
- R5: In synchronized mode each result is divided by the number of samples actually accumulated in that interval.
- R6: The sample that follows a closing sample is the first sample of the next interval, so no sample is dropped between intervals.
- R7: After reset all outputs are zero. The done output is high for exactly one cycle per interval, and all four results change only in that cycle.
- R8: In synchronized mode, once the number of samples since the last crossing reaches twice the effective sample count, a waiting block starts accumulating and an open interval closes as soon as it holds at least the effective sample count. No synchronized interval exceeds twice that count.
- R9: Cycles with the valid strobe low leave every result unchanged. Full-scale samples accumulate without overflow.
- R10: The done pulse follows the closing sample by at most 53 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe, one pulse per sample |
| p_smp_i | input | 16 | Signed instantaneous active power |
| q_smp_i | input | 16 | Signed instantaneous reactive power |
| i_smp_i | input | 16 | Signed current sample |
| v_smp_i | input | 16 | Signed voltage sample |
| sync_mode_i | input | 1 | 0 = fixed count, 1 = line-synchronized |
| n_samples_i | input | 16 | Programmed sample count |
| half_cycles_i | input | 16 | Programmed half-cycle count |
| p_ofs_i | input | 16 | Signed offset for active power |
| q_ofs_i | input | 16 | Signed offset for reactive power |
| p_avg_o | output | 32 | Averaged active power |
| q_avg_o | output | 32 | Averaged reactive power |
| i_ms_o | output | 32 | Current mean square |
| v_ms_o | output | 32 | Voltage mean square |
| done_o | output | 1 | One-cycle pulse when new results are valid |

## Verification
The assertions check several properties on every cycle: the done pulse lasts one cycle, the results hold between pulses, the effective sample count never drops below its floor, a new division is never launched while one is still running, the interval counter stays under its cap, and the mean squares stay within full scale. Only the bench scenarios can show that the numbers are right. These cover truncation of negative means, the exact sample on which each interval closes under both rules, the discard before the first crossing, tracking a change in half-period length, the half-cycle count of zero, the silent-line fallback, and that samples with the strobe low are ignored.

// File: rtl/avg_pkg.sv
package avg_pkg;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int SQ_W   = 2 * DATA_W;
    localparam int NCNT_W = CNT_W + 1;
    localparam int ACC_W  = SQ_W + NCNT_W;
    localparam int RES_W  = SQ_W;
    localparam int MIN_N  = 100;
    localparam int LANES  = 4;
    localparam int LN_P   = 0;
    localparam int LN_Q   = 1;
    localparam int LN_I   = 2;
    localparam int LN_V   = 3;

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_SYNC  = 1'b1
    } avg_mode_e;

    typedef struct packed {
        logic [ACC_W-1:0] p;
        logic [ACC_W-1:0] q;
        logic [ACC_W-1:0] i2;
        logic [ACC_W-1:0] v2;
    } acc_set_t;

    function automatic logic [CNT_W-1:0] floor_count(input logic [CNT_W-1:0] n);
        return (n < CNT_W'(MIN_N)) ? CNT_W'(MIN_N) : n;
    endfunction

    function automatic logic [ACC_W-1:0] magnitude(input logic [ACC_W-1:0] x);
        return x[ACC_W-1] ? (~x + 1'b1) : x;
    endfunction
endpackage

// File: rtl/avg_zc_detect.sv
module avg_zc_detect
    import avg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             v_sign,
    input  logic [CNT_W-1:0] n_set,
    output logic             zc,
    output logic             lost
);
    logic              prev_sign;
    logic              have_prev;
    logic [NCNT_W-1:0] quiet_q;
    logic [NCNT_W-1:0] quiet_nx;

    assign zc = smp_vld && have_prev && (v_sign != prev_sign);

    always_comb begin
        quiet_nx = quiet_q;
        if (zc)
            quiet_nx = '0;
        else if (quiet_q != {NCNT_W{1'b1}})
            quiet_nx = quiet_q + 1'b1;
    end

    assign lost = smp_vld && (quiet_nx >= {n_set, 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sign <= 1'b0;
            have_prev <= 1'b0;
            quiet_q   <= '0;
        end else if (smp_vld) begin
            prev_sign <= v_sign;
            have_prev <= 1'b1;
            quiet_q   <= quiet_nx;
        end
    end
endmodule

// File: rtl/avg_accum.sv
module avg_accum
    import avg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  avg_mode_e                mode,
    input  logic signed [DATA_W-1:0] p_smp,
    input  logic signed [DATA_W-1:0] q_smp,
    input  logic signed [DATA_W-1:0] i_smp,
    input  logic signed [DATA_W-1:0] v_smp,
    input  logic [CNT_W-1:0]         n_set,
    input  logic [CNT_W-1:0]         c_set,
    input  logic                     zc,
    input  logic                     lost,
    output logic                     close_o,
    output acc_set_t                 snap_o,
    output logic [NCNT_W-1:0]        snap_n_o,
    output logic [NCNT_W-1:0]        cnt_o
);
    logic              active_q;
    logic [NCNT_W-1:0] n_q;
    logic [NCNT_W-1:0] n_nx;
    logic [NCNT_W-1:0] cross_q;
    logic [NCNT_W-1:0] cross_nx;
    logic [NCNT_W-1:0] c_eff;
    acc_set_t          sum_q;
    acc_set_t          sum_nx;
    logic signed [SQ_W-1:0] i_sq;
    logic signed [SQ_W-1:0] v_sq;
    logic              run;
    logic              end_fix;
    logic              end_sync;
    logic              close;

    assign i_sq     = SQ_W'(i_smp) * SQ_W'(i_smp);
    assign v_sq     = SQ_W'(v_smp) * SQ_W'(v_smp);
    assign sum_nx.p  = sum_q.p  + ACC_W'(p_smp);
    assign sum_nx.q  = sum_q.q  + ACC_W'(q_smp);
    assign sum_nx.i2 = sum_q.i2 + {{(ACC_W-SQ_W){1'b0}}, i_sq};
    assign sum_nx.v2 = sum_q.v2 + {{(ACC_W-SQ_W){1'b0}}, v_sq};

    assign n_nx     = n_q + 1'b1;
    assign cross_nx = cross_q + NCNT_W'(zc);
    assign c_eff    = (c_set == '0) ? NCNT_W'(1) : {1'b0, c_set};
    assign run      = active_q || (mode == MODE_FIXED);
    assign end_fix  = n_nx >= {1'b0, n_set};
    assign end_sync = (zc && (cross_nx >= c_eff))
                   || (lost && (n_nx >= {1'b0, n_set}))
                   || (n_nx >= {n_set, 1'b0});
    assign close    = smp_vld && run && ((mode == MODE_SYNC) ? end_sync : end_fix);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            n_q      <= '0;
            cross_q  <= '0;
            sum_q    <= '0;
            close_o  <= 1'b0;
            snap_o   <= '0;
            snap_n_o <= '0;
        end else begin
            close_o <= close;
            if (smp_vld) begin
                if (!run) begin
                    if (zc || lost) active_q <= 1'b1;
                end else if (close) begin
                    snap_o   <= sum_nx;
                    snap_n_o <= n_nx;
                    sum_q    <= '0;
                    n_q      <= '0;
                    cross_q  <= '0;
                    active_q <= 1'b1;
                end else begin
                    sum_q   <= sum_nx;
                    n_q     <= n_nx;
                    cross_q <= cross_nx;
                end
            end
        end
    end

    assign cnt_o = n_q;
endmodule

// File: rtl/avg_seq_div.sv
module avg_seq_div #(
    parameter int DVD_W = 49,
    parameter int DVS_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dvd_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic [DVD_W-1:0] quo_o,
    output logic             fin_o,
    output logic             busy_o
);
    localparam int CW = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W:0]   rem_sh;
    logic             ge;
    logic [CW-1:0]    cnt_q;

    assign rem_sh = {rem_q, dvd_q[DVD_W-1]};
    assign ge     = rem_sh >= {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            dvs_q  <= '0;
            rem_q  <= '0;
            quo_o  <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
            fin_o  <= 1'b0;
        end else if (start_i) begin
            dvd_q  <= dvd_i;
            dvs_q  <= dvs_i;
            rem_q  <= '0;
            quo_o  <= '0;
            cnt_q  <= CW'(DVD_W);
            busy_o <= 1'b1;
            fin_o  <= 1'b0;
        end else if (busy_o) begin
            dvd_q <= dvd_q << 1;
            rem_q <= ge ? DVS_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVS_W-1:0];
            quo_o <= {quo_o[DVD_W-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy_o <= 1'b0;
                fin_o  <= 1'b1;
            end
        end else begin
            fin_o <= 1'b0;
        end
    end
endmodule

// File: rtl/avg_lowrate_engine.sv
module avg_lowrate_engine
    import avg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld_i,
    input  logic signed [15:0]      p_smp_i,
    input  logic signed [15:0]      q_smp_i,
    input  logic signed [15:0]      i_smp_i,
    input  logic signed [15:0]      v_smp_i,
    input  logic                    sync_mode_i,
    input  logic [15:0]             n_samples_i,
    input  logic [15:0]             half_cycles_i,
    input  logic signed [15:0]      p_ofs_i,
    input  logic signed [15:0]      q_ofs_i,
    output logic signed [31:0]      p_avg_o,
    output logic signed [31:0]      q_avg_o,
    output logic [31:0]             i_ms_o,
    output logic [31:0]             v_ms_o,
    output logic                    done_o
);
    logic [CNT_W-1:0]  n_set;
    logic              zc;
    logic              lost;
    logic              close_q;
    acc_set_t          snap;
    logic [NCNT_W-1:0] snap_n;
    logic [NCNT_W-1:0] acc_cnt;
    logic [ACC_W-1:0]  dvd [LANES];
    logic [ACC_W-1:0]  quo [LANES];
    logic [LANES-1:0]  fin;
    logic [LANES-1:0]  busy;
    logic signed [RES_W-1:0] p_mean;
    logic signed [RES_W-1:0] q_mean;

    assign n_set = floor_count(n_samples_i);

    avg_zc_detect u_zc (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld_i),
        .v_sign  (v_smp_i[DATA_W-1]),
        .n_set   (n_set),
        .zc      (zc),
        .lost    (lost)
    );

    avg_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld_i),
        .mode     (avg_mode_e'(sync_mode_i)),
        .p_smp    (p_smp_i),
        .q_smp    (q_smp_i),
        .i_smp    (i_smp_i),
        .v_smp    (v_smp_i),
        .n_set    (n_set),
        .c_set    (half_cycles_i),
        .zc       (zc),
        .lost     (lost),
        .close_o  (close_q),
        .snap_o   (snap),
        .snap_n_o (snap_n),
        .cnt_o    (acc_cnt)
    );

    assign dvd[LN_P] = magnitude(snap.p);
    assign dvd[LN_Q] = magnitude(snap.q);
    assign dvd[LN_I] = snap.i2;
    assign dvd[LN_V] = snap.v2;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            avg_seq_div #(.DVD_W(ACC_W), .DVS_W(NCNT_W)) u_div (
                .clk     (clk),
                .rst     (rst),
                .start_i (close_q),
                .dvd_i   (dvd[g]),
                .dvs_i   (snap_n),
                .quo_o   (quo[g]),
                .fin_o   (fin[g]),
                .busy_o  (busy[g])
            );
        end
    endgenerate

    assign p_mean = snap.p[ACC_W-1] ? -RES_W'(quo[LN_P]) : RES_W'(quo[LN_P]);
    assign q_mean = snap.q[ACC_W-1] ? -RES_W'(quo[LN_Q]) : RES_W'(quo[LN_Q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_avg_o <= '0;
            q_avg_o <= '0;
            i_ms_o  <= '0;
            v_ms_o  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= fin[LN_P];
            if (fin[LN_P]) begin
                p_avg_o <= p_mean + RES_W'(p_ofs_i);
                q_avg_o <= q_mean + RES_W'(q_ofs_i);
                i_ms_o  <= RES_W'(quo[LN_I]);
                v_ms_o  <= RES_W'(quo[LN_V]);
            end
        end
    end
endmodule

// File: rtl/avg_lowrate_chk.sv
module avg_lowrate_chk
    import avg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done_o,
    input logic [RES_W-1:0]  p_avg_o,
    input logic [RES_W-1:0]  q_avg_o,
    input logic [RES_W-1:0]  i_ms_o,
    input logic [RES_W-1:0]  v_ms_o,
    input logic              close_q,
    input logic [LANES-1:0]  busy,
    input logic [CNT_W-1:0]  n_set,
    input logic [NCNT_W-1:0] acc_cnt
);
    localparam logic [RES_W-1:0] MS_MAX = RES_W'(1) << (SQ_W - 2);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_results_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(p_avg_o) && $stable(q_avg_o) && $stable(i_ms_o) && $stable(v_ms_o)));

    assert_count_floor_R2: assert property (@(posedge clk) disable iff (rst)
        n_set >= CNT_W'(MIN_N));

    assert_no_relaunch_R10: assert property (@(posedge clk) disable iff (rst)
        close_q |-> (busy == '0));

    assert_interval_cap_R8: assert property (@(posedge clk) disable iff (rst)
        acc_cnt < {n_set, 1'b0});

    assert_ms_range_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((i_ms_o <= MS_MAX) && (v_ms_o <= MS_MAX)));
endmodule

bind avg_lowrate_engine avg_lowrate_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .done_o  (done_o),
    .p_avg_o (p_avg_o),
    .q_avg_o (q_avg_o),
    .i_ms_o  (i_ms_o),
    .v_ms_o  (v_ms_o),
    .close_q (close_q),
    .busy    (busy),
    .n_set   (n_set),
    .acc_cnt (acc_cnt)
);

// File: tb/tb_avg_lowrate_engine.sv
module tb_avg_lowrate_engine;
    localparam int LAT_MAX = 53;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld_i = 1'b0;
    logic signed [15:0] p_smp_i = '0, q_smp_i = '0, i_smp_i = '0, v_smp_i = '0;
    logic sync_mode_i = 1'b0;
    logic [15:0] n_samples_i = 16'd100, half_cycles_i = 16'd1;
    logic signed [15:0] p_ofs_i = '0, q_ofs_i = '0;
    logic signed [31:0] p_avg_o, q_avg_o;
    logic [31:0] i_ms_o, v_ms_o;
    logic done_o;

    avg_lowrate_engine dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    longint cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc = cyc + 1;

    // reference model state
    bit m_sync, m_active, m_prev, m_have;
    longint m_nset, m_cset, m_quiet, m_n, m_cross;
    longint m_sp, m_sq, m_si, m_sv;
    longint m_pofs, m_qofs;
    longint eq_p[$], eq_q[$], eq_i[$], eq_v[$], eq_cyc[$];
    string  eq_tag[$];
    longint last_p, last_q, last_i, last_v;
    string  cur_tag;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_sample(input longint p, input longint q, input longint i, input longint v);
        bit sgn, zc, lost, run, cls;
        sgn = (v < 0);
        zc = m_have && (sgn != m_prev);
        m_prev = sgn;
        m_have = 1;
        m_quiet = zc ? 0 : m_quiet + 1;
        lost = (m_quiet >= 2 * m_nset);
        run = m_active || !m_sync;
        if (!run) begin
            if (zc || lost) m_active = 1;
            return;
        end
        m_n++;
        if (zc) m_cross++;
        m_sp += p; m_sq += q; m_si += i * i; m_sv += v * v;
        if (m_sync)
            cls = (zc && m_cross >= m_cset) || (lost && m_n >= m_nset) || (m_n >= 2 * m_nset);
        else
            cls = (m_n >= m_nset);
        if (cls) begin
            eq_p.push_back(m_sp / m_n + m_pofs);
            eq_q.push_back(m_sq / m_n + m_qofs);
            eq_i.push_back(m_si / m_n);
            eq_v.push_back(m_sv / m_n);
            eq_cyc.push_back(cyc + 1);
            eq_tag.push_back(cur_tag);
            m_n = 0; m_cross = 0; m_sp = 0; m_sq = 0; m_si = 0; m_sv = 0;
        end
    endtask

    // compare outputs on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done_o) begin
                if (eq_p.size() == 0) begin
                    check(0, "R7 unexpected done", 1, 0);
                end else begin
                    longint ep, eqv, ei, ev, ec;
                    string t;
                    ep = eq_p.pop_front(); eqv = eq_q.pop_front();
                    ei = eq_i.pop_front(); ev = eq_v.pop_front();
                    ec = eq_cyc.pop_front(); t = eq_tag.pop_front();
                    check(longint'(p_avg_o) == ep, {t, " p_avg R3"}, longint'(p_avg_o), ep);
                    check(longint'(q_avg_o) == eqv, {t, " q_avg R3"}, longint'(q_avg_o), eqv);
                    check(longint'(i_ms_o) == ei, {t, " i_ms R3"}, longint'(i_ms_o), ei);
                    check(longint'(v_ms_o) == ev, {t, " v_ms R3"}, longint'(v_ms_o), ev);
                    check((cyc - ec) <= LAT_MAX, {t, " latency R10"}, cyc - ec, LAT_MAX);
                    last_p = ep; last_q = eqv; last_i = ei; last_v = ev;
                end
            end else begin
                check(longint'(p_avg_o) == last_p && longint'(q_avg_o) == last_q &&
                      longint'(i_ms_o) == last_i && longint'(v_ms_o) == last_v,
                      "R7 R9 hold between done", longint'(p_avg_o), last_p);
            end
        end
    end

    task automatic send(input int p, input int q, input int i, input int v);
        @(negedge clk);
        smp_vld_i = 1; p_smp_i = 16'(p); q_smp_i = 16'(q); i_smp_i = 16'(i); v_smp_i = 16'(v);
        model_sample(p, q, i, v);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            smp_vld_i = 0;
            // junk on data pins while the strobe is low: must be ignored (R9)
            p_smp_i = 16'($urandom); q_smp_i = 16'($urandom);
            i_smp_i = 16'($urandom); v_smp_i = 16'($urandom);
        end
    endtask

    task automatic start(input bit sync, input int nset, input int cset, input int po, input int qo, input string tag);
        repeat (LAT_MAX + 8) @(negedge clk);
        check(eq_p.size() == 0, {cur_tag, " R7 missing done"}, eq_p.size(), 0);
        eq_p.delete(); eq_q.delete(); eq_i.delete(); eq_v.delete(); eq_cyc.delete(); eq_tag.delete();
        rst = 1; smp_vld_i = 0;
        sync_mode_i = sync; n_samples_i = 16'(nset); half_cycles_i = 16'(cset);
        p_ofs_i = 16'(po); q_ofs_i = 16'(qo);
        m_sync = sync; m_active = 0; m_prev = 0; m_have = 0;
        m_nset = (nset < 100) ? 100 : nset;
        m_cset = (cset == 0) ? 1 : cset;
        m_quiet = 0; m_n = 0; m_cross = 0; m_sp = 0; m_sq = 0; m_si = 0; m_sv = 0;
        m_pofs = po; m_qofs = qo;
        last_p = 0; last_q = 0; last_i = 0; last_v = 0;
        cur_tag = tag;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(p_avg_o == 0 && q_avg_o == 0 && i_ms_o == 0 && v_ms_o == 0 && !done_o,
              {tag, " R7 reset state"}, longint'(p_avg_o), 0);
    endtask

    task automatic run_sync(input int count, input int half, input int base);
        for (int k = 0; k < count; k++) begin
            int mag = 100 + ((k * 7) % 50);
            int v = (((k + base) / half) % 2) ? -mag : mag;
            send(((k * 29) % 1601) - 800, 300 - ((k * 13) % 701), (k * 97) % 4000 - 2000, v);
        end
    endtask

    initial begin
        // R1 R3 R6: fixed mode, three back-to-back intervals of 100
        start(0, 100, 1, 25, -40, "R1 fixed100");
        for (int k = 0; k < 300; k++)
            send(((k * 37) % 2001) - 1000, 700 - ((k * 53) % 3001), ((k * 211) % 65536) - 32768,
                 ((k * 149) % 40001) - 20000);

        // R2: count below floor acts as 100
        start(0, 37, 1, 0, 0, "R2 clamp");
        for (int k = 0; k < 200; k++)
            send(k - 90, -k, k * 3, 1000 - k);

        // R1: negative means truncate toward zero, count 130
        start(0, 130, 1, -7, 9, "R1 neg130");
        for (int k = 0; k < 260; k++)
            send(-((k * 17) % 333) - 1, -((k * 5) % 77) - 2, (k % 9) - 4, -(k % 11));

        // R9: full-scale samples
        start(0, 100, 1, 0, 0, "R9 fullscale");
        for (int k = 0; k < 200; k++)
            send(-32768, 32767, -32768, -32768);

        // R4 R5 R6: synchronized mode, four half-cycles, period changes mid-run
        start(1, 4000, 4, 11, -3, "R4 R5 sync");
        run_sync(400, 37, 5);
        run_sync(400, 29, 0);

        // R4: half-cycle count 0 acts as 1
        start(1, 4000, 0, 0, 0, "R4 cset0");
        run_sync(200, 41, 3);

        // R8: silent line falls back to the sample count
        start(1, 100, 4, 0, 0, "R8 fallback");
        for (int k = 0; k < 600; k++)
            send(k % 100, -(k % 50), 300, 500 + (k % 40));

        // R8: crossings too sparse for the half-cycle count, interval capped
        start(1, 100, 20, 0, 0, "R8 cap");
        run_sync(500, 150, 0);

        repeat (LAT_MAX + 8) @(negedge clk);
        check(eq_p.size() == 0, "R7 final missing done", eq_p.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule